// File: doc/BRIEF.md
# Programmable Transition Event Queue

This block holds the pending firing requests of one transition in a hardware net-execution engine. A request strobe adds one event to a saturating count. A fired strobe from the firing engine removes one event. The block tells the engine through `not_empty_o` whether a request is available, and it raises `overflow_o` while the count sits at its ceiling.

A mode input selects how events behave. In persistent mode an event waits until it is consumed. In automatic mode the transition always requests a firing. In transient mode an event that is not consumed within a short window after it arrives is discarded, so an enable that comes late cannot use it.

Changing the mode flushes every pending event. The strobes are single-cycle control pulses with no handshake: every strobe is accepted in the cycle it is high, and there is no back-pressure. The event source decoding and the firing selection sit outside this block.

Top module: `evq_slot`

## Requirements
- R1: After reset, with `mode_i` = 0, the count is zero, `not_empty_o` is 0 and `overflow_o` is 0.
- R2: The encoding of `mode_i` is: 0 selects persistent, 1 selects automatic, 2 selects transient. Code 3 behaves exactly as persistent.
- R3: In persistent mode, a lone `evt_inc_i` adds one to the count and a lone `fire_dec_i` subtracts one, from the next clock edge. In every mode except automatic, `not_empty_o` is 1 exactly when the count is nonzero.
- R4: When `evt_inc_i` and `fire_dec_i` are both high in one cycle, the count is unchanged.
- R5: A lone `fire_dec_i` while the count is zero leaves the count at zero.
- R6: The count saturates at 2^CNT_W-1 (15 by default), and a further lone increment leaves it there. `overflow_o` is 1 exactly while the count equals that ceiling.
- R7: While `mode_i` = 1, `not_empty_o` is 1 in the same cycle, whatever the count. The count still follows the strobes.
- R8: In transient mode, an event sampled at edge k is visible for EXPIRE_CYC cycles (default 2). A fired strobe sampled in that window consumes it. If no new event arrives, the count is cleared at edge k+EXPIRE_CYC.
- R9: In transient mode, each new event restarts the expiry window from the edge that samples it.
- R10: At the first edge that samples a new `mode_i` value, the count and the expiry timer are cleared, and both strobes in that cycle are ignored.
- R11: In persistent mode, with both strobes low, the count holds indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Event semantics select (0 persistent, 1 automatic, 2 transient, 3 as persistent) |
| evt_inc_i | input | 1 | One new firing request this cycle |
| fire_dec_i | input | 1 | The transition fired this cycle |
| not_empty_o | output | 1 | A firing request is available |
| overflow_o | output | 1 | The count is at its ceiling |

## Verification
The bound checker watches, on every cycle, these properties:
- automatic mode forces a request;
- the count holds when there are no strobes and when both strobes arrive together;
- the count stays at zero on a decrement at zero and stays at the ceiling on an increment at the ceiling;
- a mode change or a last-cycle timer clears the count.

Only the bench scenarios show the full timing of a transient event:
- it is visible for exactly two cycles;
- a consume can land inside the window;
- a retrigger restarts the window.

The bench scenarios also show that code 3 behaves as persistent and that the count survives a long idle stretch. The reference model in the bench compares both outputs after every clock.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    EVQ_PERSIST   = 2'd0,
    EVQ_AUTO      = 2'd1,
    EVQ_TRANSIENT = 2'd2,
    EVQ_ALT       = 2'd3
  } evq_mode_e;
endpackage

// File: rtl/evq_mode_track.sv
module evq_mode_track
  import evq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [1:0] mode_i,
  output logic      mode_chg_o,
  output logic      transient_o,
  output logic      auto_o
);
  evq_mode_e mode_q;
  evq_mode_e mode_now;

  assign mode_now    = evq_mode_e'(mode_i);
  assign mode_chg_o  = (mode_now != mode_q);
  assign transient_o = (mode_now == EVQ_TRANSIENT);
  assign auto_o      = (mode_now == EVQ_AUTO);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= EVQ_PERSIST;
    else        mode_q <= mode_now;
  end
endmodule

// File: rtl/evq_sat_counter.sv
module evq_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o,
  output logic             at_zero_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o     = cnt_q;
  assign at_max_o  = (cnt_q == CNT_MAX);
  assign at_zero_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (clr_i)                         cnt_q <= '0;
    else if (inc_i && !dec_i && !at_max_o)  cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && !at_zero_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/evq_expiry_timer.sv
module evq_expiry_timer #(
  parameter int EXPIRE_CYC = 2,
  parameter int TMR_W      = $clog2(EXPIRE_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             arm_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             expire_o
);
  localparam logic [TMR_W-1:0] LOAD = TMR_W'(EXPIRE_CYC);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(1);

  logic [TMR_W-1:0] tmr_q;

  assign tmr_o    = tmr_q;
  assign expire_o = en_i && !clr_i && !arm_i && (tmr_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            tmr_q <= '0;
    else if (clr_i)        tmr_q <= '0;
    else if (arm_i)        tmr_q <= LOAD;
    else if (tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end
endmodule

// File: rtl/evq_slot.sv
module evq_slot #(
  parameter int CNT_W      = 4,
  parameter int EXPIRE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       evt_inc_i,
  input  logic       fire_dec_i,
  output logic       not_empty_o,
  output logic       overflow_o
);
  localparam int TMR_W = $clog2(EXPIRE_CYC + 1);

  logic             mode_chg;
  logic             is_transient;
  logic             is_auto;
  logic             expire;
  logic             cnt_clr;
  logic             at_max;
  logic             at_zero;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;

  evq_mode_track u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .mode_chg_o  (mode_chg),
    .transient_o (is_transient),
    .auto_o      (is_auto)
  );

  evq_expiry_timer #(.EXPIRE_CYC(EXPIRE_CYC), .TMR_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (mode_chg),
    .en_i     (is_transient),
    .arm_i    (is_transient && evt_inc_i),
    .tmr_o    (tmr_q),
    .expire_o (expire)
  );

  assign cnt_clr = mode_chg || expire;

  evq_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (cnt_clr),
    .inc_i     (evt_inc_i),
    .dec_i     (fire_dec_i),
    .cnt_o     (cnt_q),
    .at_max_o  (at_max),
    .at_zero_o (at_zero)
  );

  assign not_empty_o = is_auto || !at_zero;
  assign overflow_o  = at_max;
endmodule

// File: rtl/evq_slot_chk.sv
module evq_slot_chk #(
  parameter int CNT_W = 4,
  parameter int TMR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             evt_inc_i,
  input logic             fire_dec_i,
  input logic             not_empty_o,
  input logic             overflow_o,
  input logic [CNT_W-1:0] cnt,
  input logic             mode_chg,
  input logic [TMR_W-1:0] tmr
);
  // R7
  auto_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1) |-> not_empty_o);

  // R11
  persist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 && !mode_chg && !evt_inc_i && !fire_dec_i) |=> $stable(cnt));

  // R4
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && evt_inc_i && fire_dec_i) |=> $stable(cnt));

  // R5
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && cnt == '0 && fire_dec_i && !evt_inc_i) |=> (cnt == '0));

  // R6
  ceiling_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && overflow_o && evt_inc_i && !fire_dec_i) |=> overflow_o);

  // R10
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt == '0));

  // R8
  expiry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && !mode_chg && !evt_inc_i && tmr == TMR_W'(1)) |=> (cnt == '0));
endmodule

bind evq_slot evq_slot_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .evt_inc_i   (evt_inc_i),
  .fire_dec_i  (fire_dec_i),
  .not_empty_o (not_empty_o),
  .overflow_o  (overflow_o),
  .cnt         (cnt_q),
  .mode_chg    (mode_chg),
  .tmr         (tmr_q)
);

// File: tb/evq_slot_tb_top.sv
module evq_slot_tb_top;
  localparam int CNT_W  = 4;
  localparam int EXP    = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       evt_inc = 1'b0;
  logic       fire_dec = 1'b0;
  logic       not_empty;
  logic       overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_cnt = 0;
  int m_tmr = 0;
  int m_prev = 0;

  always #10 clk = ~clk;

  evq_slot #(.CNT_W(CNT_W), .EXPIRE_CYC(EXP)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .evt_inc_i   (evt_inc),
    .fire_dec_i  (fire_dec),
    .not_empty_o (not_empty),
    .overflow_o  (overflow)
  );

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic inc, input logic dec, input int md);
    int nc;
    if (md != m_prev) begin
      m_cnt = 0; m_tmr = 0; m_prev = md;
    end else begin
      nc = m_cnt;
      if (inc && !dec && nc < CMAX) nc++;
      else if (dec && !inc && nc > 0) nc--;
      if (md == 2) begin
        if (inc) m_tmr = EXP;
        else if (m_tmr == 1) begin nc = 0; m_tmr = 0; end
        else if (m_tmr > 0) m_tmr--;
      end
      m_cnt = nc;
    end
  endtask

  task automatic step(input logic inc, input logic dec, input int md, input string req);
    evt_inc = inc; fire_dec = dec; mode = md[1:0];
    @(posedge clk);
    model_edge(inc, dec, md);
    @(negedge clk);
    check_bit(req, "not_empty", not_empty, (md == 1) || (m_cnt != 0));
    check_bit(req, "overflow", overflow, m_cnt == CMAX);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit("R1", "not_empty", not_empty, 1'b0);
    check_bit("R1", "overflow", overflow, 1'b0);
    rst_n = 1'b1;
    m_cnt = 0; m_tmr = 0; m_prev = 0;

    // R3: increments then decrements in persistent mode
    repeat (3) step(1, 0, 0, "R3");
    repeat (2) step(0, 1, 0, "R3");
    // R11: long idle hold
    repeat (6) step(0, 0, 0, "R11");
    // R4: simultaneous strobes
    repeat (2) step(1, 1, 0, "R4");
    // R5: drain then decrement at zero
    repeat (3) step(0, 1, 0, "R5");
    step(1, 1, 0, "R5");
    // R6: saturate at ceiling
    repeat (CMAX + 3) step(1, 0, 0, "R6");
    step(0, 1, 0, "R6");
    step(1, 0, 0, "R6");
    // R10: switch to transient, strobe ignored, count flushed
    step(1, 0, 2, "R10");
    step(0, 0, 2, "R10");
    // R8: expiry without consume
    step(1, 0, 2, "R8");
    repeat (3) step(0, 0, 2, "R8");
    // R8: consume in first cycle of window
    step(1, 0, 2, "R8");
    step(0, 1, 2, "R8");
    step(0, 0, 2, "R8");
    // R8: consume on the last edge of window
    step(1, 0, 2, "R8");
    step(0, 0, 2, "R8");
    step(0, 1, 2, "R8");
    // R9: retrigger restarts window
    step(1, 0, 2, "R9");
    step(0, 0, 2, "R9");
    step(1, 0, 2, "R9");
    step(0, 0, 2, "R9");
    step(0, 0, 2, "R9");
    step(0, 0, 2, "R9");
    // R9: stacked events expire together
    step(1, 0, 2, "R9");
    step(1, 0, 2, "R9");
    repeat (3) step(0, 0, 2, "R9");
    // R7: automatic mode requests at zero count, counter still counts
    step(0, 0, 1, "R7");
    step(1, 0, 1, "R7");
    step(0, 1, 1, "R7");
    step(0, 1, 1, "R7");
    // R2: code 3 behaves as persistent
    repeat (2) step(1, 0, 3, "R2");
    repeat (4) step(0, 0, 3, "R2");
    step(0, 1, 3, "R2");
    // R10: change back to persistent flushes count
    step(0, 0, 0, "R10");
    step(0, 0, 0, "R10");
    // R10: change into automatic with pending count, then back
    repeat (2) step(1, 0, 0, "R10");
    step(0, 0, 1, "R10");
    step(0, 0, 0, "R10");

    done = 1'b1;
    finish_run();
  end
endmodule